// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block manages receive buffer descriptors for packet reassembly on a small set of circuits. A reassembly engine reports events: the start of a packet, the filling of the current buffer, and the end of a packet. The block answers each event by taking descriptors from a free queue, binding them to circuit slots, and posting finished descriptors to a ready queue. Each slot holds one open descriptor pointer, the circuit or message identifier recorded when the packet started, and an age counter.

A timer tick advances the age of every open slot. A slot that sees the configured number of ticks with no event is posted with a timeout status and then closed. When a descriptor is needed and the free queue is empty, the packet is dropped and a saturating loss counter goes up. Every post to the ready queue raises an interrupt pulse in the same cycle. The block stores no packet data.

Top module: `rbd_mgr`

## Requirements
- R1: While reset is low and in the first cycle after it, `freePop`, `rdyPush` and `irq` are 0, `lossCnt` is 0, and no slot is open. A slot opened before a reset is closed by it, so a later end event on that circuit posts nothing.
- R2: A start event (`evKind`=1) on a closed circuit, with `freeValid`=1, raises `freePop` combinationally in the same cycle. It binds `freeDesc` and `evTag` to that circuit and posts nothing.
- R3: An end event (`evKind`=3) on an open circuit posts that circuit's descriptor with status 0 (done) in the following cycle, and closes the slot.
- R4: A buffer-full event (`evKind`=2) on an open circuit, with `freeValid`=1, posts the old descriptor with status 1 (chain) in the following cycle. In the same cycle as the event it pops a new descriptor into the slot and restarts its age. The recorded identifier is kept.
- R5: A start event on an open circuit posts the old descriptor with status 3 (abort). It then opens a new packet with the new identifier when a free descriptor is available.
- R6: A start or buffer-full event that needs a descriptor while `freeValid`=0 pops nothing and increments `lossCnt`, which saturates at all ones. If the circuit was open, its descriptor is posted with status 3 and the slot closes.
- R7: An open slot that receives `TO_TICKS` ticks with no event is posted with status 2 (timeout) and closed. The post appears the cycle after the edge that sampled the final tick.
- R8: Only one post is made per cycle. An event that binds, closes or posts defers pending timeouts. Several expired slots are posted one per cycle, lowest circuit index first.
- R9: `irq` is 1 exactly in the cycles in which `rdyPush` is 1.
- R10: Buffer-full and end events on a closed circuit have no effect: no pop, no post, no change to `lossCnt`.
- R11: Every ready entry carries in `rdyTag` the identifier recorded by the start event of its packet, including entries posted after chaining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evKind | input | 2 | Event code: 0 idle, 1 start, 2 buffer full, 3 end |
| evCirc | input | CW | Circuit index of the event |
| evTag | input | TW | Circuit/message identifier, sampled on start |
| tick | input | 1 | Ageing timer tick |
| freeValid | input | 1 | Free queue holds an entry |
| freeDesc | input | DW | Descriptor pointer at the free queue head |
| freePop | output | 1 | Consume the free queue head this cycle |
| rdyPush | output | 1 | Ready queue write strobe |
| rdyDesc | output | DW | Posted descriptor pointer |
| rdyTag | output | TW | Identifier recorded for the posted descriptor |
| rdyStatus | output | 2 | 0 done, 1 chain, 2 timeout, 3 abort |
| irq | output | 1 | Interrupt pulse on each post |
| lossCnt | output | LW | Saturating count of dropped packets |

## Verification
The assertions take for granted that `freeDesc` is meaningful whenever `freeValid` is high. They also assume the ready queue takes every push, since the block has no stall input, and that `evCirc` addresses an existing circuit. The stimulus drives only circuit indices below `NCIRC` and leaves `evKind` idle on cycles that test ticks alone. It also raises `freeValid` only when the bench model has a descriptor to offer. Ticks are issued in isolated bursts so that the bench can predict each slot's age independently of event timing.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_START = 2'd1,
    EV_FULL  = 2'd2,
    EV_END   = 2'd3
  } evKind_e;

  typedef enum logic [1:0] {
    ST_DONE    = 2'd0,
    ST_CHAIN   = 2'd1,
    ST_TIMEOUT = 2'd2,
    ST_ABORT   = 2'd3
  } rdyStat_e;

  // Strobes from control to datapath, all for the slot named by tgt.
  typedef struct packed {
    logic     bindNew;   // load freeDesc into the slot, open it, clear age
    logic     loadTag;   // also capture evTag
    logic     closeSlot; // mark the slot closed
    logic     pushOld;   // post the slot's current descriptor
    logic     lossInc;   // a packet was dropped
    rdyStat_e status;    // status code for the post
  } strobe_t;

endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter int NCIRC = 4,
  parameter int CW    = 2
) (
  input  logic [1:0]       evKind,
  input  logic [CW-1:0]    evCirc,
  input  logic             freeValid,
  input  logic [NCIRC-1:0] slotOpen,
  input  logic [NCIRC-1:0] slotExp,
  output strobe_t          st,
  output logic [CW-1:0]    tgt
);

  logic evOpen;
  logic evAct;
  logic found;

  always_comb begin
    st     = '0;
    tgt    = evCirc;
    evOpen = slotOpen[evCirc];
    found  = 1'b0;

    case (evKind)
      EV_START: begin
        if (evOpen) begin
          st.pushOld = 1'b1;
          st.status  = ST_ABORT;
        end
        if (freeValid) begin
          st.bindNew = 1'b1;
          st.loadTag = 1'b1;
        end else begin
          st.lossInc = 1'b1;
          if (evOpen) st.closeSlot = 1'b1;
        end
      end
      EV_FULL: begin
        if (evOpen) begin
          st.pushOld = 1'b1;
          if (freeValid) begin
            st.status  = ST_CHAIN;
            st.bindNew = 1'b1;
          end else begin
            st.status    = ST_ABORT;
            st.closeSlot = 1'b1;
            st.lossInc   = 1'b1;
          end
        end
      end
      EV_END: begin
        if (evOpen) begin
          st.pushOld   = 1'b1;
          st.closeSlot = 1'b1;
          st.status    = ST_DONE;
        end
      end
      default: ;
    endcase

    // Timeouts use the slot port only when the event leaves it free.
    evAct = st.bindNew | st.closeSlot | st.pushOld;
    if (!evAct) begin
      for (int i = 0; i < NCIRC; i++) begin
        if (slotExp[i] && !found) begin
          found        = 1'b1;
          tgt          = CW'(i);
          st.pushOld   = 1'b1;
          st.closeSlot = 1'b1;
          st.status    = ST_TIMEOUT;
        end
      end
    end
  end

endmodule

// File: rtl/rbd_dpath.sv
module rbd_dpath
  import rbd_pkg::*;
#(
  parameter int NCIRC    = 4,
  parameter int CW       = 2,
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter int LW       = 4,
  parameter int TO_TICKS = 4,
  localparam int AW      = $clog2(TO_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [CW-1:0]    tgt,
  input  logic             tick,
  input  logic [TW-1:0]    evTag,
  input  logic [DW-1:0]    freeDesc,
  output logic [NCIRC-1:0] slotOpen,
  output logic [NCIRC-1:0] slotExp,
  output logic             rdyPush,
  output logic [DW-1:0]    rdyDesc,
  output logic [TW-1:0]    rdyTag,
  output logic [1:0]       rdyStatus,
  output logic             irq,
  output logic [LW-1:0]    lossCnt
);

  localparam logic [AW-1:0] AGE_LIM = AW'(TO_TICKS);

  logic [DW-1:0] descArr [NCIRC];
  logic [TW-1:0] tagArr  [NCIRC];

  for (genvar g = 0; g < NCIRC; g++) begin : gSlot
    logic          openQ;
    logic [DW-1:0] descQ;
    logic [TW-1:0] tagQ;
    logic [AW-1:0] ageQ;
    logic          hit;

    assign hit = (tgt == CW'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        descQ <= '0;
        tagQ  <= '0;
        ageQ  <= '0;
      end else if (hit && st.bindNew) begin
        openQ <= 1'b1;
        descQ <= freeDesc;
        ageQ  <= '0;
        if (st.loadTag) tagQ <= evTag;
      end else if (hit && st.closeSlot) begin
        openQ <= 1'b0;
        ageQ  <= '0;
      end else if (openQ && tick && (ageQ != AGE_LIM)) begin
        ageQ <= ageQ + 1'b1;
      end
    end

    assign slotOpen[g] = openQ;
    assign slotExp[g]  = openQ && (ageQ == AGE_LIM);
    assign descArr[g]  = descQ;
    assign tagArr[g]   = tagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdyPush   <= 1'b0;
      irq       <= 1'b0;
      rdyDesc   <= '0;
      rdyTag    <= '0;
      rdyStatus <= '0;
      lossCnt   <= '0;
    end else begin
      rdyPush <= st.pushOld;
      irq     <= st.pushOld;
      if (st.pushOld) begin
        rdyDesc   <= descArr[tgt];
        rdyTag    <= tagArr[tgt];
        rdyStatus <= st.status;
      end
      if (st.lossInc && (lossCnt != {LW{1'b1}})) lossCnt <= lossCnt + 1'b1;
    end
  end

endmodule

// File: rtl/rbd_mgr.sv
module rbd_mgr
  import rbd_pkg::*;
#(
  parameter int NCIRC    = 4,
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter int LW       = 4,
  parameter int TO_TICKS = 4,
  localparam int CW      = (NCIRC > 1) ? $clog2(NCIRC) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    evKind,
  input  logic [CW-1:0] evCirc,
  input  logic [TW-1:0] evTag,
  input  logic          tick,
  input  logic          freeValid,
  input  logic [DW-1:0] freeDesc,
  output logic          freePop,
  output logic          rdyPush,
  output logic [DW-1:0] rdyDesc,
  output logic [TW-1:0] rdyTag,
  output logic [1:0]    rdyStatus,
  output logic          irq,
  output logic [LW-1:0] lossCnt
);

  strobe_t          st;
  logic [CW-1:0]    tgt;
  logic [NCIRC-1:0] slotOpen;
  logic [NCIRC-1:0] slotExp;

  rbd_ctrl #(.NCIRC(NCIRC), .CW(CW)) u_ctrl (
    .evKind   (evKind),
    .evCirc   (evCirc),
    .freeValid(freeValid),
    .slotOpen (slotOpen),
    .slotExp  (slotExp),
    .st       (st),
    .tgt      (tgt)
  );

  rbd_dpath #(
    .NCIRC(NCIRC), .CW(CW), .DW(DW), .TW(TW), .LW(LW), .TO_TICKS(TO_TICKS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .tgt      (tgt),
    .tick     (tick),
    .evTag    (evTag),
    .freeDesc (freeDesc),
    .slotOpen (slotOpen),
    .slotExp  (slotExp),
    .rdyPush  (rdyPush),
    .rdyDesc  (rdyDesc),
    .rdyTag   (rdyTag),
    .rdyStatus(rdyStatus),
    .irq      (irq),
    .lossCnt  (lossCnt)
  );

  assign freePop = st.bindNew;

endmodule

// File: rtl/rbd_mgr_chk.sv
module rbd_mgr_chk #(
  parameter int CW = 2,
  parameter int DW = 8,
  parameter int TW = 8,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    evKind,
  input logic          freeValid,
  input logic          freePop,
  input logic          rdyPush,
  input logic [1:0]    rdyStatus,
  input logic          irq,
  input logic [LW-1:0] lossCnt
);

  // R2: a pop is only issued against a non-empty free queue
  a_r2_pop_has_free: assert property (@(posedge clk) disable iff (!rstN)
    freePop |-> freeValid);

  // R9: interrupt pulse coincides with each post
  a_r9_irq_with_push: assert property (@(posedge clk) disable iff (!rstN)
    irq == rdyPush);

  // R6: the loss counter never goes down
  a_r6_loss_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lossCnt >= $past(lossCnt));

  // R3: a done post follows an end event
  a_r3_done_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (rdyPush && rdyStatus == 2'd0) |-> ($past(evKind) == 2'd3));

  // R4: a chain post follows a pop of a fresh descriptor
  a_r4_chain_pops: assert property (@(posedge clk) disable iff (!rstN)
    (rdyPush && rdyStatus == 2'd1) |-> $past(freePop));

endmodule

bind rbd_mgr rbd_mgr_chk #(.CW(CW), .DW(DW), .TW(TW), .LW(LW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evKind   (evKind),
  .freeValid(freeValid),
  .freePop  (freePop),
  .rdyPush  (rdyPush),
  .rdyStatus(rdyStatus),
  .irq      (irq),
  .lossCnt  (lossCnt)
);

// File: tb/rbd_mgr_tb.sv
`timescale 1ns/1ps
module rbd_mgr_tb;

  localparam int NCIRC = 4;
  localparam int CW    = 2;
  localparam int DW    = 8;
  localparam int TW    = 8;
  localparam int LW    = 4;
  localparam int TO    = 3;

  logic          clk = 1'b0;
  logic          rstN;
  logic [1:0]    evKind;
  logic [CW-1:0] evCirc;
  logic [TW-1:0] evTag;
  logic          tick;
  logic          freeValid;
  logic [DW-1:0] freeDesc;
  logic          freePop;
  logic          rdyPush;
  logic [DW-1:0] rdyDesc;
  logic [TW-1:0] rdyTag;
  logic [1:0]    rdyStatus;
  logic          irq;
  logic [LW-1:0] lossCnt;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rbd_mgr #(.NCIRC(NCIRC), .DW(DW), .TW(TW), .LW(LW), .TO_TICKS(TO)) u_dut (
    .clk(clk), .rstN(rstN), .evKind(evKind), .evCirc(evCirc), .evTag(evTag),
    .tick(tick), .freeValid(freeValid), .freeDesc(freeDesc), .freePop(freePop),
    .rdyPush(rdyPush), .rdyDesc(rdyDesc), .rdyTag(rdyTag), .rdyStatus(rdyStatus),
    .irq(irq), .lossCnt(lossCnt)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] kind;
    logic [1:0] circ;
    logic [7:0] tag;
    logic       fv;
    logic [7:0] fd;
    logic       tk;
    logic       ePop;
    logic       ePush;
    logic [1:0] eSt;
    logic [7:0] eDesc;
    logic [7:0] eTag;
    logic [3:0] eLoss;
  } vec_t;

  localparam int NV = 27;
  // status: 0 done, 1 chain, 2 timeout, 3 abort; kind: 1 start, 2 full, 3 end
  localparam vec_t VEC [NV] = '{
    '{4'd2,  2'd1, 2'd0, 8'd11, 1'b1, 8'd20, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd0}, // R2
    '{4'd3,  2'd3, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd0, 8'd20, 8'd11, 4'd0}, // R3
    '{4'd10, 2'd3, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd0}, // R10
    '{4'd10, 2'd2, 2'd1, 8'd0,  1'b1, 8'd99, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd0}, // R10
    '{4'd2,  2'd1, 2'd1, 8'd22, 1'b1, 8'd21, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd0}, // R2
    '{4'd4,  2'd2, 2'd1, 8'd0,  1'b1, 8'd22, 1'b0, 1'b1, 1'b1, 2'd1, 8'd21, 8'd22, 4'd0}, // R4
    '{4'd11, 2'd3, 2'd1, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd0, 8'd22, 8'd22, 4'd0}, // R11
    '{4'd2,  2'd1, 2'd2, 8'd33, 1'b1, 8'd23, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd0}, // R2
    '{4'd5,  2'd1, 2'd2, 8'd34, 1'b1, 8'd24, 1'b0, 1'b1, 1'b1, 2'd3, 8'd23, 8'd33, 4'd0}, // R5
    '{4'd6,  2'd1, 2'd3, 8'd44, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd1}, // R6
    '{4'd6,  2'd2, 2'd2, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd3, 8'd24, 8'd34, 4'd2}, // R6
    '{4'd10, 2'd3, 2'd2, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R10
    '{4'd2,  2'd1, 2'd0, 8'd55, 1'b1, 8'd30, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R2
    '{4'd7,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R7
    '{4'd7,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R7
    '{4'd7,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R7
    '{4'd7,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd2, 8'd30, 8'd55, 4'd2}, // R7
    '{4'd7,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R7
    '{4'd2,  2'd1, 2'd1, 8'd61, 1'b1, 8'd31, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R2
    '{4'd2,  2'd1, 2'd2, 8'd62, 1'b1, 8'd32, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R2
    '{4'd8,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R8
    '{4'd8,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R8
    '{4'd8,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R8
    '{4'd8,  2'd1, 2'd3, 8'd63, 1'b1, 8'd33, 1'b0, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0,  4'd2}, // R8
    '{4'd8,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd2, 8'd31, 8'd61, 4'd2}, // R8
    '{4'd8,  2'd0, 2'd0, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd2, 8'd32, 8'd62, 4'd2}, // R8
    '{4'd11, 2'd3, 2'd3, 8'd0,  1'b0, 8'd0,  1'b0, 1'b0, 1'b1, 2'd0, 8'd33, 8'd63, 4'd2}  // R11
  };

  task automatic chk(input string what, input int req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    evKind = 2'd0; evCirc = '0; evTag = '0; tick = 1'b0;
    freeValid = 1'b0; freeDesc = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle();
    rstN = 1'b0;
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("freePop in reset", 1, int'(freePop), 0);
    chk("rdyPush in reset", 1, int'(rdyPush), 0);
    chk("irq in reset", 1, int'(irq), 0);
    chk("lossCnt in reset", 1, int'(lossCnt), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      @(negedge clk);
      evKind = v.kind; evCirc = v.circ; evTag = v.tag; tick = v.tk;
      freeValid = v.fv; freeDesc = v.fd;
      #1;
      chk("freePop", int'(v.req), int'(freePop), int'(v.ePop));
      @(posedge clk);
      #1;
      chk("rdyPush", int'(v.req), int'(rdyPush), int'(v.ePush));
      chk("irq (R9)", int'(v.req), int'(irq), int'(v.ePush));
      chk("lossCnt", int'(v.req), int'(lossCnt), int'(v.eLoss));
      if (v.ePush) begin
        chk("rdyStatus", int'(v.req), int'(rdyStatus), int'(v.eSt));
        chk("rdyDesc", int'(v.req), int'(rdyDesc), int'(v.eDesc));
        chk("rdyTag", int'(v.req), int'(rdyTag), int'(v.eTag));
      end
    end

    // R1: a slot opened before reset is gone after it
    @(negedge clk);
    evKind = 2'd1; evCirc = 2'd0; evTag = 8'd77; freeValid = 1'b1; freeDesc = 8'd40;
    doReset();
    @(negedge clk);
    #1;
    chk("lossCnt after reset", 1, int'(lossCnt), 0);
    evKind = 2'd3; evCirc = 2'd0;
    @(posedge clk);
    #1;
    chk("end after reset posts nothing", 1, int'(rdyPush), 0);

    // R6: loss counter saturates at all ones
    @(negedge clk);
    idle();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      evKind = 2'd1; evCirc = 2'd0; freeValid = 1'b0;
      #1;
      chk("no pop with empty queue", 6, int'(freePop), 0);
    end
    @(negedge clk);
    idle();
    #1;
    chk("lossCnt saturated", 6, int'(lossCnt), 15);

    // R4: chaining restarts age; timeout counts from the chain
    @(negedge clk);
    evKind = 2'd1; evCirc = 2'd2; evTag = 8'd90; freeValid = 1'b1; freeDesc = 8'd50;
    @(negedge clk);
    idle(); tick = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    evKind = 2'd2; evCirc = 2'd2; freeValid = 1'b1; freeDesc = 8'd51;
    @(posedge clk);
    #1;
    chk("chain status", 4, int'(rdyStatus), 1);
    for (int k = 0; k < TO; k++) begin
      @(negedge clk);
      idle(); tick = 1'b1;
      @(posedge clk);
      #1;
      chk("no early timeout after chain", 4, int'(rdyPush), 0);
    end
    @(negedge clk);
    idle();
    @(posedge clk);
    #1;
    chk("timeout after chain push", 7, int'(rdyPush), 1);
    chk("timeout after chain desc", 7, int'(rdyDesc), 51);
    chk("timeout after chain tag", 11, int'(rdyTag), 90);
    chk("timeout status", 7, int'(rdyStatus), 2);

    finishRun();
  end

endmodule